// File: doc/BRIEF.md
# Byte-Wide Chained Configuration Loader

This block is the configuration intake of a programmable device that takes its configuration image one byte per edge of an externally driven configuration clock. Several such devices share one 8-bit data bus and one clock. Each device passes a loading enable to the next one in a chain: its status output drops low while it is taking data and rises again once its own frame memory is full, which lets the following device start on the bytes that come next.

Loading starts only when the 3-bit mode input selects byte-chain loading and the init input is seen high. Two internal-oscillator ticks later the device starts taking data. The first edge on which it is selected only primes the byte path, and every later selected edge stores one byte. Each frame carries a fixed start field and a fixed stop field. A byte that breaks either field stops loading for good and pulls init low. When the last byte is stored, the device lets go of the shared open-drain DONE line. It turns active only once that wired-AND line reads high through a synchroniser, so all devices in a chain start in the same cycle. A device whose DONE line floats high starts as soon as its own load is complete.

Top module: `cfg_byte_loader`

## Requirements
- R1: While `mode_sel_i` is not 3'b010 when the block is idle, no load starts: `chain_en_o` stays 1 and `done_drive_o` stays 1 whatever `init_i` and `osc_tick_i` do.
- R2: After `init_i` is sampled high while idle in mode 3'b010, `chain_en_o` stays 1 through the first sampled `osc_tick_i` pulse and goes to 0 on the clock edge that samples the second pulse.
- R3: Once loading, the first edge with `chain_sel_i` high stores nothing (priming). Each later edge with `chain_sel_i` high stores `data_i` at the next address, starting at address 0. `cfg_rd_data_o` returns the byte at `cfg_rd_addr_i` without a clock.
- R4: An edge with `chain_sel_i` low neither primes nor stores a byte, and `chain_en_o` stays 0.
- R5: Byte 0 of each frame (FRAME_BYTES bytes, default 4) must carry START_FIELD (default 4'hA) in bits [7:4]. The last byte of each frame must carry STOP_FIELD (default 4'h5) in bits [3:0]. On a mismatch the byte is not stored and `init_drive_o` goes to 1 after that edge and stays 1. No further bytes are stored, `chain_en_o` stays 0 and `done_drive_o` stays 1.
- R6: After the edge that stores the last byte (address FRAME_BYTES*NUM_FRAMES-1), `chain_en_o` is 1 and `done_drive_o` is 0. Later bytes are ignored and the memory is left unchanged.
- R7: With the memory full, `active_o` rises on the third edge that samples `done_line_i` high (two synchroniser stages) and stays 0 while `done_line_i` is low.
- R8: If `done_line_i` has been high for the whole load, `active_o` rises on the edge after the one that stores the last byte.
- R9: Reset gives `chain_en_o`=1, `done_drive_o`=1, `init_drive_o`=0 and `active_o`=0, and clears the byte address, the frame position and the error, so a new load writes from address 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Configuration clock, driven from outside |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| mode_sel_i | input | 3 | Mode select; 3'b010 selects byte-chain loading |
| init_i | input | 1 | Init status; high allows loading to start |
| osc_tick_i | input | 1 | One-cycle pulse per internal-oscillator period |
| chain_sel_i | input | 1 | Select from the previous device's status output |
| data_i | input | 8 | Configuration data byte |
| done_line_i | input | 1 | Level of the shared wired-AND DONE line |
| cfg_rd_addr_i | input | log2(FRAME_BYTES*NUM_FRAMES) | Frame memory read address |
| cfg_rd_data_o | output | 8 | Frame memory read data |
| chain_en_o | output | 1 | Status to the next device; 0 while loading |
| done_drive_o | output | 1 | 1 = pull DONE low (open-drain enable) |
| init_drive_o | output | 1 | 1 = pull init low after a field error |
| active_o | output | 1 | Device has started operation |

## Verification
A wrong byte address or frame position shows up twice at the ports. Stored bytes land in the wrong place, which the read port exposes once loading ends. Field checks also fire on payload bytes, so `init_drive_o` rises within one edge of the misplaced byte. A state register stuck in the wrong phase shows as `chain_en_o` dropping a tick early or late, `done_drive_o` releasing before the last byte, or `active_o` rising a cycle off from the two-stage DONE synchroniser count. All of these are visible within a few cycles of the event that should cause them.

// File: rtl/cfg_loader_pkg.sv
package cfg_loader_pkg;

  localparam logic [2:0] MODE_BYTE_CHAIN = 3'b010;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_ARM    = 3'd1,
    ST_LOAD   = 3'd2,
    ST_FULL   = 3'd3,
    ST_ACTIVE = 3'd4,
    ST_ERROR  = 3'd5
  } ld_state_e;

endpackage

// File: rtl/cfg_rst_sync.sv
module cfg_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q_n
);

  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= {chain_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_q_n = chain_q[STAGES-1];

endmodule

// File: rtl/cfg_level_sync.sv
module cfg_level_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_i,
  output logic sync_o
);

  logic [STAGES-1:0] stage_q;

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage_q[s] <= 1'b0;
          else        stage_q[s] <= async_i;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage_q[s] <= 1'b0;
          else        stage_q[s] <= stage_q[s-1];
        end
      end
    end
  endgenerate

  assign sync_o = stage_q[STAGES-1];

endmodule

// File: rtl/cfg_field_check.sv
module cfg_field_check #(
  parameter logic [3:0] START_FIELD = 4'hA,
  parameter logic [3:0] STOP_FIELD  = 4'h5
) (
  input  logic [7:0] byte_i,
  input  logic       is_first_i,
  input  logic       is_last_i,
  output logic       ok_o
);

  logic start_ok;
  logic stop_ok;

  always_comb begin
    start_ok = (byte_i[7:4] == START_FIELD);
    stop_ok  = (byte_i[3:0] == STOP_FIELD);
    ok_o     = (!is_first_i || start_ok) && (!is_last_i || stop_ok);
  end

endmodule

// File: rtl/cfg_frame_mem.sv
module cfg_frame_mem #(
  parameter int DEPTH  = 16,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [7:0]        wr_data_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [7:0]        rd_data_o
);

  logic [7:0] mem_q [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en_i) begin
      mem_q[wr_addr_i] <= wr_data_i;
    end
  end

  assign rd_data_o = mem_q[rd_addr_i];

endmodule

// File: rtl/cfg_byte_loader.sv
module cfg_byte_loader
  import cfg_loader_pkg::*;
#(
  parameter int         FRAME_BYTES = 4,
  parameter int         NUM_FRAMES  = 4,
  parameter int         SYNC_STAGES = 2,
  parameter logic [3:0] START_FIELD = 4'hA,
  parameter logic [3:0] STOP_FIELD  = 4'h5
) (
  input  logic                                        clk,
  input  logic                                        rst_n,
  input  logic [2:0]                                  mode_sel_i,
  input  logic                                        init_i,
  input  logic                                        osc_tick_i,
  input  logic                                        chain_sel_i,
  input  logic [7:0]                                  data_i,
  input  logic                                        done_line_i,
  input  logic [$clog2(FRAME_BYTES*NUM_FRAMES)-1:0]   cfg_rd_addr_i,
  output logic [7:0]                                  cfg_rd_data_o,
  output logic                                        chain_en_o,
  output logic                                        done_drive_o,
  output logic                                        init_drive_o,
  output logic                                        active_o
);

  localparam int DEPTH  = FRAME_BYTES * NUM_FRAMES;
  localparam int ADDR_W = $clog2(DEPTH);
  localparam int BIDX_W = (FRAME_BYTES > 1) ? $clog2(FRAME_BYTES) : 1;
  localparam logic [ADDR_W-1:0] LAST_ADDR = ADDR_W'(DEPTH - 1);
  localparam logic [BIDX_W-1:0] LAST_BIDX = BIDX_W'(FRAME_BYTES - 1);

  logic rst_q_n;
  logic done_sync;

  ld_state_e         state_q, state_d;
  logic              tick_seen_q, tick_seen_d;
  logic              primed_q, primed_d;
  logic [ADDR_W-1:0] wr_addr_q, wr_addr_d;
  logic [BIDX_W-1:0] bidx_q, bidx_d;

  logic field_ok;
  logic take_byte;
  logic wr_en;

  cfg_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_q_n (rst_q_n)
  );

  cfg_level_sync #(.STAGES(SYNC_STAGES)) u_done_sync (
    .clk     (clk),
    .rst_n   (rst_q_n),
    .async_i (done_line_i),
    .sync_o  (done_sync)
  );

  cfg_field_check #(
    .START_FIELD (START_FIELD),
    .STOP_FIELD  (STOP_FIELD)
  ) u_field_check (
    .byte_i     (data_i),
    .is_first_i (bidx_q == '0),
    .is_last_i  (bidx_q == LAST_BIDX),
    .ok_o       (field_ok)
  );

  cfg_frame_mem #(
    .DEPTH  (DEPTH),
    .ADDR_W (ADDR_W)
  ) u_frame_mem (
    .clk       (clk),
    .wr_en_i   (wr_en),
    .wr_addr_i (wr_addr_q),
    .wr_data_i (data_i),
    .rd_addr_i (cfg_rd_addr_i),
    .rd_data_o (cfg_rd_data_o)
  );

  // A byte is offered on a selected, already primed edge during loading.
  assign take_byte = (state_q == ST_LOAD) && chain_sel_i && primed_q;
  assign wr_en     = take_byte && field_ok;

  // Next-state logic
  always_comb begin
    state_d     = state_q;
    tick_seen_d = tick_seen_q;
    primed_d    = primed_q;
    wr_addr_d   = wr_addr_q;
    bidx_d      = bidx_q;

    unique case (state_q)
      ST_IDLE: begin
        if ((mode_sel_i == MODE_BYTE_CHAIN) && init_i) begin
          state_d     = ST_ARM;
          tick_seen_d = 1'b0;
        end
      end
      ST_ARM: begin
        if (!init_i) begin
          state_d = ST_IDLE;
        end else if (osc_tick_i) begin
          if (tick_seen_q) begin
            state_d   = ST_LOAD;
            primed_d  = 1'b0;
            wr_addr_d = '0;
            bidx_d    = '0;
          end else begin
            tick_seen_d = 1'b1;
          end
        end
      end
      ST_LOAD: begin
        if (chain_sel_i) begin
          if (!primed_q) begin
            primed_d = 1'b1;
          end else if (!field_ok) begin
            state_d = ST_ERROR;
          end else begin
            bidx_d    = (bidx_q == LAST_BIDX) ? '0 : bidx_q + 1'b1;
            wr_addr_d = wr_addr_q + 1'b1;
            if (wr_addr_q == LAST_ADDR) begin
              state_d   = ST_FULL;
              wr_addr_d = wr_addr_q;
            end
          end
        end
      end
      ST_FULL: begin
        if (done_sync) begin
          state_d = ST_ACTIVE;
        end
      end
      ST_ACTIVE: state_d = ST_ACTIVE;
      ST_ERROR:  state_d = ST_ERROR;
      default:   state_d = ST_IDLE;
    endcase
  end

  // State registers
  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      state_q     <= ST_IDLE;
      tick_seen_q <= 1'b0;
      primed_q    <= 1'b0;
      wr_addr_q   <= '0;
      bidx_q      <= '0;
    end else begin
      state_q     <= state_d;
      tick_seen_q <= tick_seen_d;
      primed_q    <= primed_d;
      wr_addr_q   <= wr_addr_d;
      bidx_q      <= bidx_d;
    end
  end

  // Outputs decoded from registered state only
  always_comb begin
    chain_en_o   = !((state_q == ST_LOAD) || (state_q == ST_ERROR));
    done_drive_o = !((state_q == ST_FULL) || (state_q == ST_ACTIVE));
    init_drive_o = (state_q == ST_ERROR);
    active_o     = (state_q == ST_ACTIVE);
  end

endmodule

// File: rtl/cfg_byte_loader_chk.sv
module cfg_byte_loader_chk (
  input logic clk,
  input logic rst_n,
  input logic osc_tick_i,
  input logic done_line_i,
  input logic chain_en_o,
  input logic done_drive_o,
  input logic init_drive_o,
  input logic active_o
);

  // R2: the status output can only fall on an edge that samples a tick
  a_r2_fall_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(chain_en_o) |-> $past(osc_tick_i));

  // R5: the field error is sticky
  a_r5_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    init_drive_o |=> init_drive_o);

  // R5: an errored device keeps DONE low and never starts
  a_r5_err_holds_done: assert property (@(posedge clk) disable iff (!rst_n)
    init_drive_o |-> (done_drive_o && !active_o && !chain_en_o));

  // R6: DONE is released only with the chain enable passed on
  a_r6_release_with_chain: assert property (@(posedge clk) disable iff (!rst_n)
    !done_drive_o |-> (chain_en_o && !init_drive_o));

  // R7: start-up needs the DONE line high two edges earlier
  a_r7_start_after_sync: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(active_o) |-> $past(done_line_i, 2));

  // R7: an active device has released DONE
  a_r7_active_released: assert property (@(posedge clk) disable iff (!rst_n)
    active_o |-> !done_drive_o);

endmodule

bind cfg_byte_loader cfg_byte_loader_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .osc_tick_i   (osc_tick_i),
  .done_line_i  (done_line_i),
  .chain_en_o   (chain_en_o),
  .done_drive_o (done_drive_o),
  .init_drive_o (init_drive_o),
  .active_o     (active_o)
);

// File: tb/cfg_byte_loader_bench.sv
module cfg_byte_loader_bench;

  localparam int FB    = 4;
  localparam int NF    = 4;
  localparam int DEPTH = FB * NF;
  localparam int AW    = $clog2(DEPTH);

  logic          clk = 1'b0;
  logic          rst_n;
  logic [2:0]    mode_sel;
  logic          init_in;
  logic          osc_tick;
  logic          chain_sel;
  logic [7:0]    data;
  logic          done_line;
  logic [AW-1:0] rd_addr;
  logic [7:0]    rd_data;
  logic          chain_en;
  logic          done_drive;
  logic          init_drive;
  logic          active;

  int checks = 0;
  int errors = 0;
  bit finished = 0;
  logic [7:0] exp_mem [DEPTH];

  always #2.5 clk = ~clk;

  cfg_byte_loader #(.FRAME_BYTES(FB), .NUM_FRAMES(NF)) u_cfg_byte_loader (
    .clk           (clk),
    .rst_n         (rst_n),
    .mode_sel_i    (mode_sel),
    .init_i        (init_in),
    .osc_tick_i    (osc_tick),
    .chain_sel_i   (chain_sel),
    .data_i        (data),
    .done_line_i   (done_line),
    .cfg_rd_addr_i (rd_addr),
    .cfg_rd_data_o (rd_data),
    .chain_en_o    (chain_en),
    .done_drive_o  (done_drive),
    .init_drive_o  (init_drive),
    .active_o      (active)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  // Legal byte for position b of a frame, payload from r
  function automatic logic [7:0] mk_byte(input int b, input logic [7:0] r);
    logic [7:0] v;
    v = r;
    if (b == 0)      v[7:4] = 4'hA;
    if (b == FB - 1) v[3:0] = 4'h5;
    return v;
  endfunction

  task automatic do_reset(input logic done_level);
    rst_n = 1'b0; mode_sel = 3'b000; init_in = 1'b0; osc_tick = 1'b0;
    chain_sel = 1'b0; data = 8'h00; done_line = done_level; rd_addr = '0;
    tick(); tick();
    rst_n = 1'b1;
    tick(); tick(); tick();
  endtask

  task automatic check_idle_outputs(input string req);
    chk(chain_en == 1'b1,   req, "chain_en", chain_en, 1);
    chk(done_drive == 1'b1, req, "done_drive", done_drive, 1);
    chk(init_drive == 1'b0, req, "init_drive", init_drive, 0);
    chk(active == 1'b0,     req, "active", active, 0);
  endtask

  // Enter loading and prime with a byte that would fail the start field
  task automatic start_load();
    mode_sel = 3'b010; init_in = 1'b1;
    tick();
    osc_tick = 1'b1; tick(); osc_tick = 1'b0; tick();
    chk(chain_en == 1'b1, "R2", "chain_en after first tick", chain_en, 1);
    osc_tick = 1'b1; tick(); osc_tick = 1'b0;
    chk(chain_en == 1'b0, "R2", "chain_en after second tick", chain_en, 0);
    chain_sel = 1'b1; data = 8'h00; tick();
    chk(init_drive == 1'b0, "R3", "priming byte not checked", init_drive, 0);
  endtask

  task automatic load_all(input bit gaps);
    for (int i = 0; i < DEPTH; i++) begin
      if (gaps && ($urandom % 3 == 0)) begin
        chain_sel = 1'b0; data = 8'h33; tick();
        chk(chain_en == 1'b0, "R4", "chain_en during gap", chain_en, 0);
      end
      exp_mem[i] = mk_byte(i % FB, 8'($urandom));
      chain_sel = 1'b1; data = exp_mem[i]; tick();
      if (i == DEPTH - 2)
        chk(done_drive == 1'b1, "R6", "done held before last byte", done_drive, 1);
    end
    chain_sel = 1'b0;
    chk(chain_en == 1'b1,   "R6", "chain_en after full", chain_en, 1);
    chk(done_drive == 1'b0, "R6", "done released after full", done_drive, 0);
  endtask

  task automatic check_mem(input int upto, input string req);
    for (int a = 0; a < upto; a++) begin
      rd_addr = AW'(a); #1;
      chk(rd_data == exp_mem[a], req, "memory byte", rd_data, exp_mem[a]);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1234_5678));

    // R9 reset state
    do_reset(1'b0);
    check_idle_outputs("R9");

    // R1 wrong mode: nothing starts
    mode_sel = 3'b011; init_in = 1'b1;
    for (int k = 0; k < 6; k++) begin
      osc_tick = k[0]; tick();
    end
    osc_tick = 1'b0;
    chk(chain_en == 1'b1,   "R1", "chain_en wrong mode", chain_en, 1);
    chk(done_drive == 1'b1, "R1", "done_drive wrong mode", done_drive, 1);

    // R2..R7 full load with gaps, DONE held low by another device
    do_reset(1'b0);
    start_load();
    load_all(1'b1);
    check_mem(DEPTH, "R3");
    for (int k = 0; k < 3; k++) begin
      chain_sel = 1'b1; data = 8'($urandom); tick();
    end
    chain_sel = 1'b0;
    chk(chain_en == 1'b1, "R6", "chain_en stays high", chain_en, 1);
    check_mem(DEPTH, "R6");
    tick(); tick(); tick();
    chk(active == 1'b0, "R7", "active while DONE low", active, 0);
    done_line = 1'b1;
    tick(); tick();
    chk(active == 1'b0, "R7", "active after two edges", active, 0);
    tick();
    chk(active == 1'b1, "R7", "active after three edges", active, 1);

    // R8 floating DONE: start right after own completion
    do_reset(1'b1);
    start_load();
    load_all(1'b0);
    chk(active == 1'b0, "R8", "active on full edge", active, 0);
    tick();
    chk(active == 1'b1, "R8", "active one edge later", active, 1);

    // R5 start-field error in frame 1
    do_reset(1'b0);
    start_load();
    for (int i = 0; i < FB; i++) begin
      exp_mem[i] = mk_byte(i, 8'($urandom));
      chain_sel = 1'b1; data = exp_mem[i]; tick();
    end
    data = {4'h3, 4'h5}; tick();
    chk(init_drive == 1'b1, "R5", "init_drive on bad start", init_drive, 1);
    for (int k = 0; k < 5; k++) begin
      data = mk_byte(k % FB, 8'($urandom)); tick();
    end
    chain_sel = 1'b0;
    chk(init_drive == 1'b1, "R5", "init_drive sticky", init_drive, 1);
    chk(chain_en == 1'b0,   "R5", "chain_en low on error", chain_en, 0);
    chk(done_drive == 1'b1, "R5", "done held on error", done_drive, 1);
    check_mem(FB, "R5");

    // R9 reset clears the error
    do_reset(1'b0);
    check_idle_outputs("R9");

    // R5 stop-field error on byte 3 of frame 0
    start_load();
    for (int i = 0; i < FB - 1; i++) begin
      exp_mem[i] = mk_byte(i, 8'($urandom));
      chain_sel = 1'b1; data = exp_mem[i]; tick();
    end
    chk(init_drive == 1'b0, "R5", "no error on good bytes", init_drive, 0);
    data = 8'hA6; tick();
    chain_sel = 1'b0;
    chk(init_drive == 1'b1, "R5", "init_drive on bad stop", init_drive, 1);
    check_mem(FB - 1, "R5");

    // R9 fresh load after reset starts from address 0
    do_reset(1'b0);
    start_load();
    load_all(1'b1);
    check_mem(DEPTH, "R9");

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule